// File: doc/BRIEF.md
# I2C Master Command and Receive Queues

This block holds the two queues between a register bus and the bit-level engine of an I2C master. On the transmit side, each write to the command port puts one 9-bit entry into a command queue. When bit 8 of the entry is clear, bits 7:0 are a byte to send. When bit 8 is set, the entry is a read request and carries no data. The engine drains the command queue through a valid/ready handshake. Bytes that the engine receives fill a separate receive queue, and software pops them by reading the data port.

Software sees the fill level of each queue. It sets a threshold for each queue and gets two flags back:
- a receive-ready flag, raised once enough bytes are waiting;
- a transmit-low flag, raised once the command queue has drained to its threshold.

A constant word reports both depths. Each read request takes up one future receive slot, so software has to keep its outstanding reads within the free receive space.

An abort from the engine empties both queues at once. Three one-cycle pulses report misuse:
- a push into a full command queue;
- a pop from an empty receive queue;
- a received byte arriving while the receive queue is full.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A command-port write with bit 8 clear queues bits 8:0 unchanged. A write with bit 8 set queues 0x100, so its data byte is discarded. The engine gets the entries in write order on `eng_cmd_data`.
- R2: While `rd_en` is high and the receive queue is not empty, `rd_data` shows the oldest received byte. The byte is removed at that clock edge, and bytes come out in arrival order.
- R3: `tx_level` and `rx_level` give the current entry counts. They change in the cycle after the edge that pushes or pops, and they never exceed the configured depth.
- R4: `depth_info` has the command depth minus one in bits 23:16 and the receive depth minus one in bits 15:8. All other bits are zero.
- R5: `rx_full_flag` is high exactly when `rx_level` is greater than `rx_thresh`. With a threshold of 0, a single byte raises it.
- R6: `tx_empty_flag` is high exactly when `tx_level` is at or below `tx_thresh`.
- R7: A cycle with `abort` high empties both queues, so both levels read 0 in the next cycle. In that cycle, pushes, pops and received bytes have no effect, and `eng_cmd_valid` is low.
- R8: A write while the command queue is full is dropped. The level stays the same, and `tx_overflow` pulses high for the following cycle.
- R9: `rd_en` on an empty receive queue gives `rd_data` = 0, and `rx_underflow` pulses high for the following cycle.
- R10: A byte arriving while the receive queue is full is dropped, and the queued bytes stay as they were. `rx_overflow` pulses high for the following cycle.
- R11: `eng_cmd_valid` is high whenever the command queue is not empty and `abort` is low. An entry leaves the queue at an edge where both valid and `eng_cmd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command-port write strobe |
| wr_data | input | 9 | Command entry: bit 8 marks a read request, bits 7:0 are the byte to send |
| rd_en | input | 1 | Data-port read strobe, which pops one received byte |
| rd_data | output | 8 | Oldest received byte, or 0 when the queue is empty |
| tx_thresh | input | THR_W | Command-queue low threshold |
| rx_thresh | input | THR_W | Receive-queue threshold |
| abort | input | 1 | Transfer abort, which empties both queues |
| eng_cmd_valid | output | 1 | A command entry is available to the engine |
| eng_cmd_ready | input | 1 | The engine takes the entry at the head of the queue |
| eng_cmd_data | output | 9 | Entry at the head of the command queue |
| eng_rx_valid | input | 1 | The engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_level | output | 9 | Command queue fill level |
| rx_level | output | 9 | Receive queue fill level |
| tx_empty_flag | output | 1 | Command level at or below its threshold |
| rx_full_flag | output | 1 | Receive level above its threshold |
| tx_overflow | output | 1 | Pulse: a write was dropped because the command queue was full |
| rx_underflow | output | 1 | Pulse: a pop found the receive queue empty |
| rx_overflow | output | 1 | Pulse: a received byte was dropped because the receive queue was full |
| depth_info | output | 32 | Constant word reporting the two queue depths |

## Verification
The properties assume that every input is a known value from the first clock edge after reset is released. They also assume that each pulse on `eng_rx_valid` or `wr_en` stands for exactly one item per cycle, and that thresholds change only between clock edges. The stimulus drives every input on the falling clock edge and holds it for a full cycle. It raises a strobe for one cycle per item. It keeps `eng_cmd_ready` and `rd_en` low during the abort cycle, so the scoreboard's expected queues can be cleared at a known point.

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;
   localparam int LVL_W    = 9;
   localparam int BYTE_W   = 8;
   localparam int CMD_W    = BYTE_W + 1;
   localparam int READ_BIT = BYTE_W;
   localparam int MAX_DEPTH = 256;

   typedef logic [LVL_W-1:0]  level_t;
   typedef logic [CMD_W-1:0]  cmd_t;
   typedef logic [BYTE_W-1:0] byte_t;

   // A read request keeps only its marker bit; the byte field is cleared.
   function automatic cmd_t normalize_cmd(input cmd_t c);
      return c[READ_BIT] ? cmd_t'(1 << READ_BIT) : c;
   endfunction
endpackage

// File: rtl/i2c_cmdq_fifo.sv
module i2c_cmdq_fifo
   import i2c_cmdq_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output level_t           level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   level_t           count;
   logic             do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == LVL_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];
   assign level   = count;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + level_t'(do_push) - level_t'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/i2c_cmdq_thresh.sv
module i2c_cmdq_thresh
   import i2c_cmdq_pkg::*;
#(
   parameter int THR_W = 8
) (
   input  level_t           tx_level,
   input  level_t           rx_level,
   input  logic [THR_W-1:0] tx_thresh,
   input  logic [THR_W-1:0] rx_thresh,
   output logic             tx_low,
   output logic             rx_high
);
   level_t tx_lim, rx_lim;

   assign tx_lim  = LVL_W'(tx_thresh);
   assign rx_lim  = LVL_W'(rx_thresh);
   assign tx_low  = (tx_level <= tx_lim);
   assign rx_high = (rx_level >  rx_lim);
endmodule

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue
   import i2c_cmdq_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int THR_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [8:0]       wr_data,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   input  logic [THR_W-1:0] tx_thresh,
   input  logic [THR_W-1:0] rx_thresh,
   input  logic             abort,
   output logic             eng_cmd_valid,
   input  logic             eng_cmd_ready,
   output logic [8:0]       eng_cmd_data,
   input  logic             eng_rx_valid,
   input  logic [7:0]       eng_rx_data,
   output logic [8:0]       tx_level,
   output logic [8:0]       rx_level,
   output logic             tx_empty_flag,
   output logic             rx_full_flag,
   output logic             tx_overflow,
   output logic             rx_underflow,
   output logic             rx_overflow,
   output logic [31:0]      depth_info
);
   localparam logic [31:0] DEPTH_WORD =
      {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

   generate
      if (TX_DEPTH < 2 || TX_DEPTH > MAX_DEPTH) begin : g_bad_tx_depth
         $error("TX_DEPTH must lie in 2..256");
      end
      if (RX_DEPTH < 2 || RX_DEPTH > MAX_DEPTH) begin : g_bad_rx_depth
         $error("RX_DEPTH must lie in 2..256");
      end
      if (THR_W < 1 || THR_W > LVL_W) begin : g_bad_thr_w
         $error("THR_W must lie in 1..9");
      end
   endgenerate

   cmd_t   tx_in, tx_head;
   byte_t  rx_head;
   logic   tx_empty_i, tx_full_i, rx_empty_i, rx_full_i;
   level_t tx_lvl_i, rx_lvl_i;
   logic   tx_ovf_q, rx_unf_q, rx_ovf_q;

   assign tx_in = normalize_cmd(wr_data);

   i2c_cmdq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (abort),
      .push  (wr_en && !abort),
      .din   (tx_in),
      .pop   (eng_cmd_ready && !abort),
      .dout  (tx_head),
      .empty (tx_empty_i),
      .full  (tx_full_i),
      .level (tx_lvl_i)
   );

   i2c_cmdq_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (abort),
      .push  (eng_rx_valid && !abort),
      .din   (eng_rx_data),
      .pop   (rd_en && !abort),
      .dout  (rx_head),
      .empty (rx_empty_i),
      .full  (rx_full_i),
      .level (rx_lvl_i)
   );

   i2c_cmdq_thresh #(.THR_W(THR_W)) u_thr (
      .tx_level  (tx_lvl_i),
      .rx_level  (rx_lvl_i),
      .tx_thresh (tx_thresh),
      .rx_thresh (rx_thresh),
      .tx_low    (tx_empty_flag),
      .rx_high   (rx_full_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ovf_q <= 1'b0;
         rx_unf_q <= 1'b0;
         rx_ovf_q <= 1'b0;
      end else begin
         tx_ovf_q <= wr_en        && !abort && tx_full_i;
         rx_unf_q <= rd_en        && !abort && rx_empty_i;
         rx_ovf_q <= eng_rx_valid && !abort && rx_full_i;
      end
   end

   assign eng_cmd_valid = !tx_empty_i && !abort;
   assign eng_cmd_data  = tx_head;
   assign rd_data       = rx_empty_i ? '0 : rx_head;
   assign tx_level      = tx_lvl_i;
   assign rx_level      = rx_lvl_i;
   assign tx_overflow   = tx_ovf_q;
   assign rx_underflow  = rx_unf_q;
   assign rx_overflow   = rx_ovf_q;
   assign depth_info    = DEPTH_WORD;
endmodule

// File: rtl/i2c_cmd_queue_chk.sv
module i2c_cmd_queue_chk #(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int THR_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [8:0]       wr_data,
   input logic             rd_en,
   input logic [7:0]       rd_data,
   input logic [THR_W-1:0] tx_thresh,
   input logic [THR_W-1:0] rx_thresh,
   input logic             abort,
   input logic             eng_cmd_valid,
   input logic             eng_cmd_ready,
   input logic [8:0]       eng_cmd_data,
   input logic             eng_rx_valid,
   input logic [7:0]       eng_rx_data,
   input logic [8:0]       tx_level,
   input logic [8:0]       rx_level,
   input logic             tx_empty_flag,
   input logic             rx_full_flag,
   input logic             tx_overflow,
   input logic             rx_underflow,
   input logic             rx_overflow,
   input logic [31:0]      depth_info
);
   AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_cmd_valid && eng_cmd_data[8]) |-> (eng_cmd_data[7:0] == 8'h00)); // R1
   AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= 9'(TX_DEPTH)); // R3
   AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= 9'(RX_DEPTH)); // R3
   AST_RX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full_flag == (rx_level > 9'(rx_thresh))); // R5
   AST_TX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_flag == (tx_level <= 9'(tx_thresh))); // R6
   AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (tx_level == '0 && rx_level == '0)); // R7
   AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !abort && tx_level == 9'(TX_DEPTH)) |=> tx_overflow); // R8
   AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !abort && tx_level == 9'(TX_DEPTH) && !eng_cmd_ready)
      |=> (tx_level == $past(tx_level))); // R8
   AST_RX_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rx_level == '0) |-> (rd_data == 8'h00)); // R9
   AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !abort && rx_level == '0) |=> rx_underflow); // R9
   AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_valid && !abort && rx_level == 9'(RX_DEPTH)) |=> rx_overflow); // R10
   AST_CMD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid == (tx_level != '0 && !abort)); // R11
endmodule

bind i2c_cmd_queue i2c_cmd_queue_chk #(
   .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .THR_W(THR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .tx_thresh(tx_thresh),
   .rx_thresh(rx_thresh), .abort(abort), .eng_cmd_valid(eng_cmd_valid),
   .eng_cmd_ready(eng_cmd_ready), .eng_cmd_data(eng_cmd_data),
   .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
   .tx_level(tx_level), .rx_level(rx_level), .tx_empty_flag(tx_empty_flag),
   .rx_full_flag(rx_full_flag), .tx_overflow(tx_overflow),
   .rx_underflow(rx_underflow), .rx_overflow(rx_overflow),
   .depth_info(depth_info)
);

// File: tb/i2c_cmd_queue_test.sv
`timescale 1ns/1ps
module i2c_cmd_queue_test;
   localparam int TXD = 8;
   localparam int RXD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] tx_thresh = 8'd2;
   logic [7:0] rx_thresh = 8'd0;
   logic       abort = 1'b0;
   logic       eng_cmd_valid;
   logic       eng_cmd_ready = 1'b0;
   logic [8:0] eng_cmd_data;
   logic       eng_rx_valid = 1'b0;
   logic [7:0] eng_rx_data = '0;
   logic [8:0] tx_level, rx_level;
   logic       tx_empty_flag, rx_full_flag;
   logic       tx_overflow, rx_underflow, rx_overflow;
   logic [31:0] depth_info;

   int checks = 0;
   int errors = 0;
   int cmds_seen = 0;
   logic [8:0] exp_cmd[$];
   logic [7:0] exp_rx[$];

   always #4 clk = ~clk;

   i2c_cmd_queue #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .THR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .tx_thresh(tx_thresh),
      .rx_thresh(rx_thresh), .abort(abort), .eng_cmd_valid(eng_cmd_valid),
      .eng_cmd_ready(eng_cmd_ready), .eng_cmd_data(eng_cmd_data),
      .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
      .tx_level(tx_level), .rx_level(rx_level), .tx_empty_flag(tx_empty_flag),
      .rx_full_flag(rx_full_flag), .tx_overflow(tx_overflow),
      .rx_underflow(rx_underflow), .rx_overflow(rx_overflow),
      .depth_info(depth_info)
   );

   task automatic check_eq(input string req, input logic [31:0] act,
                           input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: command write; records the expected engine-side entry.
   task automatic push_cmd(input logic [8:0] d);
      logic full_now;
      full_now = (exp_cmd.size() >= TXD);
      if (!full_now) exp_cmd.push_back(d[8] ? 9'h100 : d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      check_eq(full_now ? "R8 overflow pulse" : "R8 no overflow",
               32'(tx_overflow), 32'(full_now));
   endtask

   // Driver: engine delivers a received byte.
   task automatic rx_byte(input logic [7:0] b);
      logic full_now;
      full_now = (exp_rx.size() >= RXD);
      if (!full_now) exp_rx.push_back(b);
      eng_rx_valid = 1'b1; eng_rx_data = b;
      @(negedge clk);
      eng_rx_valid = 1'b0;
      check_eq(full_now ? "R10 overflow pulse" : "R10 no overflow",
               32'(rx_overflow), 32'(full_now));
   endtask

   task automatic pop_rx();
      logic empty_now;
      empty_now = (exp_rx.size() == 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check_eq("R9 underflow pulse", 32'(rx_underflow), 32'(empty_now));
   endtask

   task automatic drain_cmds();
      eng_cmd_ready = 1'b1;
      for (int i = 0; i < 40 && tx_level != 0; i++) @(negedge clk);
      eng_cmd_ready = 1'b0;
      check_eq("R11 drained level", 32'(tx_level), 32'd0);
      check_eq("R11 valid low when empty", 32'(eng_cmd_valid), 32'd0);
   endtask

   // Monitor: compares handshakes and data-port reads against the queues.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (eng_cmd_valid && eng_cmd_ready) begin
               cmds_seen++;
               if (exp_cmd.size() == 0)
                  check_eq("R1 unexpected entry", 32'(eng_cmd_data), 32'h1ff);
               else
                  check_eq("R1 entry order", 32'(eng_cmd_data), 32'(exp_cmd.pop_front()));
            end
            if (rd_en) begin
               if (exp_rx.size() == 0)
                  check_eq("R9 empty read zero", 32'(rd_data), 32'd0);
               else
                  check_eq("R2 byte order", 32'(rd_data), 32'(exp_rx.pop_front()));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      check_eq("R3 reset tx level", 32'(tx_level), 32'd0);
      check_eq("R3 reset rx level", 32'(rx_level), 32'd0);
      check_eq("R11 reset valid", 32'(eng_cmd_valid), 32'd0);
      check_eq("R6 reset tx flag", 32'(tx_empty_flag), 32'd1);
      check_eq("R5 reset rx flag", 32'(rx_full_flag), 32'd0);
      check_eq("R4 depth word", depth_info, 32'h0007_0300);

      // Command queue fill, threshold 2
      push_cmd(9'h0A5);
      push_cmd(9'h1FF);
      check_eq("R3 tx level 2", 32'(tx_level), 32'd2);
      check_eq("R6 level 2 at thresh 2", 32'(tx_empty_flag), 32'd1);
      push_cmd(9'h03C);
      check_eq("R6 level 3 above thresh", 32'(tx_empty_flag), 32'd0);
      check_eq("R11 valid with entries", 32'(eng_cmd_valid), 32'd1);
      for (int i = 0; i < 5; i++) push_cmd(9'(9'h040 + i));
      check_eq("R3 tx full level", 32'(tx_level), 32'(TXD));
      push_cmd(9'h0EE);
      check_eq("R8 level unchanged", 32'(tx_level), 32'(TXD));
      @(negedge clk);
      check_eq("R8 pulse ends", 32'(tx_overflow), 32'd0);
      drain_cmds();
      check_eq("R1 entries delivered", 32'(cmds_seen), 32'(TXD));
      check_eq("R1 scoreboard empty", 32'(exp_cmd.size()), 32'd0);

      // Receive queue, threshold 0 then 2
      rx_byte(8'h11);
      check_eq("R3 rx level 1", 32'(rx_level), 32'd1);
      check_eq("R5 one byte at thresh 0", 32'(rx_full_flag), 32'd1);
      rx_thresh = 8'd2;
      #1;
      check_eq("R5 level 1 thresh 2", 32'(rx_full_flag), 32'd0);
      @(negedge clk);
      rx_byte(8'h22);
      check_eq("R5 level 2 thresh 2", 32'(rx_full_flag), 32'd0);
      rx_byte(8'h33);
      check_eq("R5 level 3 thresh 2", 32'(rx_full_flag), 32'd1);
      rx_byte(8'h44);
      rx_byte(8'h55);
      check_eq("R10 level unchanged", 32'(rx_level), 32'(RXD));
      for (int i = 0; i < RXD; i++) pop_rx();
      check_eq("R2 rx drained", 32'(rx_level), 32'd0);
      pop_rx();
      @(negedge clk);
      check_eq("R9 pulse ends", 32'(rx_underflow), 32'd0);

      // Abort flush with same-cycle requests
      push_cmd(9'h012);
      push_cmd(9'h034);
      rx_byte(8'h66);
      abort = 1'b1; wr_en = 1'b1; wr_data = 9'h077;
      eng_rx_valid = 1'b1; eng_rx_data = 8'h88;
      #1;
      check_eq("R7 valid low in abort", 32'(eng_cmd_valid), 32'd0);
      @(negedge clk);
      abort = 1'b0; wr_en = 1'b0; eng_rx_valid = 1'b0;
      exp_cmd.delete();
      exp_rx.delete();
      check_eq("R7 tx flushed", 32'(tx_level), 32'd0);
      check_eq("R7 rx flushed", 32'(rx_level), 32'd0);
      check_eq("R7 no overflow flag", 32'(tx_overflow), 32'd0);
      push_cmd(9'h0C3);
      check_eq("R7 fresh entry level", 32'(tx_level), 32'd1);
      drain_cmds();
      check_eq("R7 post-abort scoreboard", 32'(exp_cmd.size()), 32'd0);
      rx_byte(8'h99);
      pop_rx();
      check_eq("R7 rx post-abort empty", 32'(exp_rx.size()), 32'd0);

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule